// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a compact processor with a single accumulator. It steps through a program held in an external word-addressed memory, pulling one 16-bit instruction at a time, decoding it and carrying it out, and continues until it meets a halt instruction. All memory traffic goes through two holding registers: an address register that alone drives the memory address, and a data holding register that receives read words and supplies write data. A fetched instruction sits in an instruction register while its operand is accessed, and a program counter points at the next instruction.

The memory is synchronous with one cycle of read latency. The controller therefore spends a fixed eight cycles on every instruction other than halt: address set-up, read wait, data capture, instruction load with counter increment, operand address, operand access, operand capture and execute. There are no branches, so a program runs straight through, wrapping from the top word back to word zero. The block is meant for small sequencing tasks and as a reference for a fetch-execute loop.

Top module: `acc_core`

## Requirements
- R1: An instruction word carries its opcode in bits 15:12 and a direct 12-bit operand address in bits 11:0; every operand access uses that address on `mem_addr`.
- R2: Opcode 4'h1 replaces the accumulator with the memory word at the operand address.
- R3: Opcode 4'h2 writes the accumulator to the operand address: `mem_we` is high for exactly one cycle with `mem_addr` equal to the operand address and `mem_wdata` equal to the accumulator.
- R4: Opcode 4'h5 adds the memory word at the operand address to the accumulator, the sum wrapping modulo 2^16 with no carry kept.
- R5: Opcode 4'h0 halts: `halted` goes high and stays high until reset, no further write occurs and `mem_addr` stays unchanged.
- R6: Every other opcode (4'h3, 4'h4, 4'h6 to 4'hF) changes neither the accumulator nor memory.
- R7: Reset (active-low `rst_n`, asynchronous) clears the program counter and accumulator, holds `halted` and `mem_we` low, and execution then starts at address 0.
- R8: Each non-halt instruction takes 8 clock cycles; with k instructions before the halt, `halted` is first high after the (8k+5)-th rising edge following reset release.
- R9: The program counter wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the data holding register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
A wrong accumulator value stays hidden until the next store, so every generated program ends by storing the accumulator and the whole memory image is compared with a bench model after the halt. A sequencing fault in the controller shows as a wrong halt cycle, since the cycle on which `halted` rises is checked exactly against 8k+5, and a stray or misplaced write shows in the memory image or trips the write-address assertion in the same cycle. Wrap-around of the counter is exercised by a program that runs through all 4096 words and patches word 0 into a halt.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int unsigned OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;

  typedef enum logic [3:0] {
    ST_FADDR = 4'd0,  // address register <- program counter
    ST_FWAIT = 4'd1,  // memory reads instruction
    ST_FCAP  = 4'd2,  // data register <- read data
    ST_DEC   = 4'd3,  // instruction register <- data register, pc + 1
    ST_OADDR = 4'd4,  // address register <- operand address
    ST_OWAIT = 4'd5,  // operand read or write
    ST_OCAP  = 4'd6,  // data register <- operand
    ST_EXEC  = 4'd7,  // accumulator update
    ST_HALT  = 4'd8
  } state_e;
endpackage

// File: rtl/acc_core_adder.sv
module acc_core_adder #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  // carry is dropped: the sum wraps modulo 2^DATA_W
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             ld_mar_pc_o,
  output logic             ld_mar_ir_o,
  output logic             ld_mbr_mem_o,
  output logic             ld_mbr_acc_o,
  output logic             ld_ir_o,
  output logic             inc_pc_o,
  output logic             ld_acc_mbr_o,
  output logic             ld_acc_sum_o,
  output logic             mem_we_o,
  output logic             halted_o
);
  state_e state_q, state_d;

  logic is_load, is_store, is_add;
  assign is_load  = (opcode_i == OPC_LOAD);
  assign is_store = (opcode_i == OPC_STORE);
  assign is_add   = (opcode_i == OPC_ADD);

  always_comb begin
    state_d      = state_q;
    ld_mar_pc_o  = 1'b0;
    ld_mar_ir_o  = 1'b0;
    ld_mbr_mem_o = 1'b0;
    ld_mbr_acc_o = 1'b0;
    ld_ir_o      = 1'b0;
    inc_pc_o     = 1'b0;
    ld_acc_mbr_o = 1'b0;
    ld_acc_sum_o = 1'b0;
    mem_we_o     = 1'b0;
    unique case (state_q)
      ST_FADDR: begin ld_mar_pc_o = 1'b1; state_d = ST_FWAIT; end
      ST_FWAIT: state_d = ST_FCAP;
      ST_FCAP:  begin ld_mbr_mem_o = 1'b1; state_d = ST_DEC; end
      ST_DEC:   begin ld_ir_o = 1'b1; inc_pc_o = 1'b1; state_d = ST_OADDR; end
      ST_OADDR: begin
        if (opcode_i == OPC_HALT) begin
          state_d = ST_HALT;
        end else begin
          ld_mar_ir_o  = 1'b1;
          ld_mbr_acc_o = is_store;
          state_d      = ST_OWAIT;
        end
      end
      ST_OWAIT: begin mem_we_o = is_store; state_d = ST_OCAP; end
      ST_OCAP:  begin ld_mbr_mem_o = is_load | is_add; state_d = ST_EXEC; end
      ST_EXEC:  begin
        ld_acc_mbr_o = is_load;
        ld_acc_sum_o = is_add;
        state_d      = ST_FADDR;
      end
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FADDR;
    else        state_q <= state_d;
  end

  assign halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/acc_core_datapath.sv
module acc_core_datapath #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_mar_pc_i,
  input  logic              ld_mar_ir_i,
  input  logic              ld_mbr_mem_i,
  input  logic              ld_mbr_acc_i,
  input  logic              ld_ir_i,
  input  logic              inc_pc_i,
  input  logic              ld_acc_mbr_i,
  input  logic              ld_acc_sum_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, acc_q, sum;

  logic mar_en, mbr_en, acc_en;
  logic [ADDR_W-1:0] mar_d;
  logic [DATA_W-1:0] mbr_d, acc_d;

  assign mar_en = ld_mar_pc_i | ld_mar_ir_i;
  assign mar_d  = ld_mar_pc_i ? pc_q : ir_q[ADDR_W-1:0];
  assign mbr_en = ld_mbr_mem_i | ld_mbr_acc_i;
  assign mbr_d  = ld_mbr_acc_i ? acc_q : mem_rdata_i;
  assign acc_en = ld_acc_mbr_i | ld_acc_sum_i;
  assign acc_d  = ld_acc_sum_i ? sum : mbr_q;

  acc_core_adder #(.DATA_W(DATA_W)) u_adder (
    .a_i  (acc_q),
    .b_i  (mbr_q),
    .sum_o(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (inc_pc_i) pc_q  <= pc_q + 1'b1;  // wraps at 2^ADDR_W
      if (mar_en)   mar_q <= mar_d;
      if (mbr_en)   mbr_q <= mbr_d;
      if (ld_ir_i)  ir_q  <= mbr_q;
      if (acc_en)   acc_q <= acc_d;
    end
  end

  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int unsigned OP_LSB = ADDR_W;

  logic ld_mar_pc, ld_mar_ir, ld_mbr_mem, ld_mbr_acc;
  logic ld_ir, inc_pc, ld_acc_mbr, ld_acc_sum;
  logic [DATA_W-1:0] ir_q;

  acc_core_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode_i    (ir_q[DATA_W-1:OP_LSB]),
    .ld_mar_pc_o (ld_mar_pc),
    .ld_mar_ir_o (ld_mar_ir),
    .ld_mbr_mem_o(ld_mbr_mem),
    .ld_mbr_acc_o(ld_mbr_acc),
    .ld_ir_o     (ld_ir),
    .inc_pc_o    (inc_pc),
    .ld_acc_mbr_o(ld_acc_mbr),
    .ld_acc_sum_o(ld_acc_sum),
    .mem_we_o    (mem_we),
    .halted_o    (halted)
  );

  acc_core_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_mar_pc_i (ld_mar_pc),
    .ld_mar_ir_i (ld_mar_ir),
    .ld_mbr_mem_i(ld_mbr_mem),
    .ld_mbr_acc_i(ld_mbr_acc),
    .ld_ir_i     (ld_ir),
    .inc_pc_i    (inc_pc),
    .ld_acc_mbr_i(ld_acc_mbr),
    .ld_acc_sum_i(ld_acc_sum),
    .mem_rdata_i (mem_rdata),
    .mar_o       (mem_addr),
    .mbr_o       (mem_wdata),
    .ir_o        (ir_q)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              halted,
  input logic [DATA_W-1:0] ir_q
);
  assert_write_at_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == ir_q[ADDR_W-1:0]));

  assert_write_only_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ir_q[DATA_W-1:ADDR_W] == 4'h2));

  assert_single_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_no_write_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_addr(mem_addr),
  .mem_we  (mem_we),
  .halted  (halted),
  .ir_q    (ir_q)
);

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_we, halted;

  logic [DW-1:0] mem   [DEPTH];
  logic [DW-1:0] model [DEPTH];

  int checks = 0;
  int fails  = 0;
  int total_cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  acc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    total_cycles <= total_cycles + 1;
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    mem[a] = d;
    model[a] = d;
  endtask

  task automatic clear_all(input logic [DW-1:0] fill);
    for (int i = 0; i < DEPTH; i++) poke(i, fill);
  endtask

  // reference interpreter; returns number of instructions before the halt
  task automatic model_run(output int k, output logic [DW-1:0] acc);
    int pc;
    logic [3:0] op;
    int a;
    pc = 0; acc = '0; k = 0;
    for (int n = 0; n < 20000; n++) begin
      op = model[pc][15:12];
      a  = int'(model[pc][11:0]);
      if (op == 4'h0) break;
      case (op)
        4'h1: acc = model[a];
        4'h2: model[a] = acc;
        4'h5: acc = acc + model[a];
        default: ;
      endcase
      pc = (pc + 1) % DEPTH;
      k++;
    end
  endtask

  function automatic logic [DW-1:0] mk(input logic [3:0] op, input int a);
    return {op, a[AW-1:0]};
  endfunction

  task automatic run_and_check(input string name);
    int k, cyc, bad, first_bad;
    logic [DW-1:0] acc;
    logic [AW-1:0] hold_addr;
    model_run(k, acc);
    rst_n = 1'b0;
    @(negedge clk);
    check(halted == 1'b0, "R7", {name, " halted in reset"}, halted, 0);
    check(mem_we == 1'b0, "R7", {name, " we in reset"}, mem_we, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == 1) check(mem_addr == '0, "R7", {name, " first fetch address"}, mem_addr, 0);
    end while (!halted && cyc < 40000);
    check(cyc == 8 * k + 5, "R8", {name, " halt cycle"}, cyc, 8 * k + 5);
    bad = 0; first_bad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== model[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    check(bad == 0, "R2 R3 R4 R6", {name, " memory image mismatching words"}, bad, 0);
    if (first_bad >= 0)
      $display("  first mismatch at %0d: %0h vs %0h", first_bad, mem[first_bad], model[first_bad]);
    hold_addr = mem_addr;
    repeat (12) @(negedge clk);
    check(halted == 1'b1, "R5", {name, " halt held"}, halted, 1);
    check(mem_addr == hold_addr, "R5", {name, " address frozen"}, mem_addr, hold_addr);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== model[i]) bad++;
    check(bad == 0, "R5", {name, " no writes after halt"}, bad, 0);
  endtask

  initial begin : watchdog
    wait (total_cycles > 190000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<190000", total_cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [3:0] op;
    int len, pc, r;
    void'($urandom(32'd4711));
    clear_all('0);
    repeat (2) @(negedge clk);

    // immediate halt: k = 0
    run_and_check("R5 halt-at-zero");

    // R4 wrap: 0xFFFF + 0x0003 = 0x0002; R2 load, R3 store
    clear_all('0);
    poke(0, mk(4'h1, 100));
    poke(1, mk(4'h5, 101));
    poke(2, mk(4'h2, 102));
    poke(3, mk(4'h0, 0));
    poke(100, 16'hFFFF);
    poke(101, 16'h0003);
    poke(102, 16'h1234);
    run_and_check("R4 add-wrap");
    check(mem[102] == 16'h0002, "R4", "wrapped sum", mem[102], 16'h0002);

    // R6: every unused opcode is a no-op aimed at live data
    clear_all('0);
    poke(0, mk(4'h1, 100));
    pc = 1;
    for (int o = 3; o < 16; o++) if (o != 5) begin
      poke(pc, mk(o[3:0], 100)); pc++;
    end
    poke(pc, mk(4'h2, 101)); pc++;
    poke(pc, mk(4'h0, 0));
    poke(100, 16'hA5C3);
    poke(101, 16'h0000);
    run_and_check("R6 nops");
    check(mem[101] == 16'hA5C3 && mem[100] == 16'hA5C3, "R6", "acc untouched by nops",
          mem[101], 16'hA5C3);

    // constrained random programs
    for (int t = 0; t < 16; t++) begin
      clear_all('0);
      len = 6 + int'($urandom % 30);
      poke(0, mk(4'h2, 81));  // R7: accumulator starts at zero
      for (int i = 1; i <= len; i++) begin
        r = int'($urandom % 10);
        if (r < 3)      op = 4'h1;
        else if (r < 6) op = 4'h5;
        else if (r < 8) op = 4'h2;
        else begin
          op = 4'(3 + $urandom % 12);
          if (op >= 4'h5) op = op + 4'h1;
        end
        poke(i, mk(op, 64 + int'($urandom % 16)));
      end
      poke(len + 1, mk(4'h2, 80));
      poke(len + 2, mk(4'h0, 0));
      for (int d = 64; d < 82; d++)
        poke(d, ($urandom % 4 == 0) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom));
      run_and_check($sformatf("R2 R3 R4 random%0d", t));
      check(mem[81] == 16'h0000, "R7", "accumulator after reset", mem[81], 0);
    end

    // R9: run through all 4096 words, last one patches word 0 into a halt
    clear_all(mk(4'h3, 0));
    poke(DEPTH - 1, mk(4'h2, 0));
    run_and_check("R9 pc-wrap");
    check(mem[0] == 16'h0000, "R9", "word 0 patched after wrap", mem[0], 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule